// File: doc/BRIEF.md
# Direct-Mode Quad Serial Transfer Engine

This block is the host side of a serial flash link when software drives it by hand. Before a transfer, the host selects three settings. The first is the lane width: one output line, or four bidirectional lines. The second is whether the link only sends or also receives. The third is how many bytes to move. The host then pulses a start input. The engine asserts chip select and pulls entries from a transmit queue. It loads each data entry into a left-shifting register and clocks it out most significant bit first. When reception is on, it assembles the incoming bits in the same register and pushes one byte per slot into a receive queue.

An entry can carry a control tag. A tagged entry is not sent as data. It asks for a number of idle serial clocks with the data lines released, which gives the dummy cycles a flash read needs. A live remaining-byte count and a sticky finished flag let the host tell when the transfer has ended.

Each serial clock takes two system clocks: a low phase, then a high phase. The engine samples input at the end of the high phase. The queues and the register decode sit outside the block. The transmit queue is show-ahead and is popped by a one-cycle acknowledge.

Top module: `qxfer_engine`

## Requirements
- R1: A start pulse seen while enabled and idle, with a nonzero byte count, drives cs_n low on the next cycle, clears done and loads remaining with the byte count.
- R2: While enable is low, a start pulse is ignored: cs_n stays high and remaining and done keep their values.
- R3: In legacy mode (quad_mode=0), each data byte goes out on io_out[0], most significant bit first, over 8 serial clocks, with io_oe=4'b0001.
- R4: In quad mode (quad_mode=1) with rx_en=0, each byte goes out as two nibbles on io_out[3:0], high nibble first, with io_oe=4'b1111.
- R5: Remaining drops by one for each completed data byte and ends at zero.
- R6: After the last byte, cs_n returns high, done reads 1 and remaining reads 0.
- R7: With rx_en=1, each data byte slot ends with a one-cycle rx_push, and rx_data carries the received byte, first bit as the most significant. In legacy mode the bits come from io_in[1]. In quad mode they come from io_in[3:0], high nibble first. With rx_en=0, rx_push never rises.
- R8: An entry with tx_ctrl=1 produces N serial clocks, where N is tx_data[3:0]. During those clocks io_oe is 0. The entry does not change remaining and produces no rx_push.
- R9: While data is needed and the transmit queue is empty, sclk stays low and cs_n stays low.
- R10: Dropping enable during a transfer drives cs_n high on the next cycle and sets done.
- R11: In quad mode with rx_en=1, io_oe is 0 during data slots.
- R12: A start pulse with a byte count of zero sets done and leaves cs_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; low stops all activity |
| start | input | 1 | One-cycle start strobe |
| quad_mode | input | 1 | 1 = four data lines, 0 = single line |
| rx_en | input | 1 | 1 = transmit and receive, 0 = transmit only |
| byte_count | input | 16 | Number of data bytes to move |
| tx_valid | input | 1 | Transmit queue holds an entry |
| tx_data | input | 8 | Head entry of the transmit queue |
| tx_ctrl | input | 1 | Head entry is a control (dummy cycles) entry |
| tx_pop | output | 1 | Acknowledge: head entry consumed this cycle |
| rx_push | output | 1 | Received byte valid, one cycle |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Serial data out per lane |
| io_oe | output | 4 | Output enable per lane |
| io_in | input | 4 | Serial data in per lane |
| done | output | 1 | Sticky transfer-finished flag |
| remaining | output | 16 | Live remaining-byte count |

## Verification
The bench rebuilds every byte from the lane values it captures at each rising serial clock. A reversed bit order or a swapped nibble order therefore shows up as a wrong byte. A dummy entry placed between two data bytes checks three things. A design that counts the dummy entry as a byte ends early. One that drives during the idle clocks shows a nonzero enable. One that loses count gives the wrong number of clocks.

Other tests cover the corner cases where a design is likely to go wrong. In the queue-starvation test, a design that clocks anyway sends garbage. In the zero-length start, a design that starts anyway drops chip select. In the disable-mid-transfer test, a design that keeps going holds chip select low. The last test pulses start while disabled.

// File: rtl/qxfer_pkg.sv
package qxfer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SHIFT = 2'd2
   } qx_state_e;
endpackage

// File: rtl/qxfer_bytecnt.sv
module qxfer_bytecnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (dec)  count <= count - 1'b1;
   end

   // R5
   cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> count != '0);
endmodule

// File: rtl/qxfer_shifter.sv
module qxfer_shifter #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              shift,
   input  logic              quad,
   input  logic              rx_en,
   input  logic [LANES-1:0]  io_in,
   output logic [BYTE_W-1:0] sh,
   output logic [LANES-1:0]  lane_out
);
   logic [BYTE_W-1:0] nxt_leg, nxt_quad;

   assign nxt_leg = {sh[BYTE_W-2:0], rx_en & io_in[1]};

   generate
      if (BYTE_W == LANES) begin : g_one_beat
         assign nxt_quad = rx_en ? io_in : '0;
      end else begin : g_multi_beat
         assign nxt_quad = {sh[BYTE_W-LANES-1:0], rx_en ? io_in : {LANES{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= load_val;
      else if (shift) sh <= quad ? nxt_quad : nxt_leg;
   end

   assign lane_out = quad ? sh[BYTE_W-1 -: LANES]
                          : {{(LANES-1){1'b0}}, sh[BYTE_W-1]};

   // R3
   load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/qxfer_engine.sv
module qxfer_engine
   import qxfer_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LANES   = 4,
   parameter int CNT_W   = 16,
   parameter int DUMMY_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic              quad_mode,
   input  logic              rx_en,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic              tx_valid,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ctrl,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [BYTE_W-1:0] rx_data,
   output logic              sclk,
   output logic              cs_n,
   output logic [LANES-1:0]  io_out,
   output logic [LANES-1:0]  io_oe,
   input  logic [LANES-1:0]  io_in,
   output logic              done,
   output logic [CNT_W-1:0]  remaining
);
   localparam int BIT_CW  = $clog2(BYTE_W + 1);
   localparam int CYC_W   = (DUMMY_W > BIT_CW) ? DUMMY_W : BIT_CW;
   localparam int BEATS_L = BYTE_W;
   localparam int BEATS_Q = BYTE_W / LANES;

   generate
      if (BYTE_W % LANES != 0) begin : g_bad_lanes
         $error("BYTE_W must be a multiple of LANES");
      end
      if (LANES < 2) begin : g_bad_min
         $error("LANES must be at least 2");
      end
      if (DUMMY_W > BYTE_W) begin : g_bad_dummy
         $error("DUMMY_W must fit in a queue entry");
      end
   endgenerate

   qx_state_e        state;
   logic             ph, dummy;
   logic [CYC_W-1:0] cyc;
   logic             go, take, last_beat, shift_en, dec;
   logic [LANES-1:0] lane_out;
   logic             data_phase;
   logic [CYC_W-1:0] dcount;

   assign dcount    = CYC_W'(tx_data[DUMMY_W-1:0]);
   assign go        = (state == ST_IDLE) && start && enable && (byte_count != '0);
   assign tx_pop    = (state == ST_LOAD) && enable && (remaining != '0) && tx_valid;
   assign take      = tx_pop && !tx_ctrl;
   assign last_beat = (state == ST_SHIFT) && enable && ph && (cyc == CYC_W'(1));
   assign shift_en  = (state == ST_SHIFT) && enable && ph && !dummy;
   assign dec       = last_beat && !dummy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ph      <= 1'b0;
         dummy   <= 1'b0;
         cyc     <= '0;
         done    <= 1'b0;
         rx_push <= 1'b0;
      end else begin
         rx_push <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start && enable) begin
                  if (byte_count == '0) done <= 1'b1;
                  else begin
                     done  <= 1'b0;
                     state <= ST_LOAD;
                  end
               end
            end
            ST_LOAD: begin
               if (!enable || remaining == '0) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else if (tx_valid) begin
                  ph <= 1'b0;
                  if (tx_ctrl) begin
                     dummy <= 1'b1;
                     cyc   <= dcount;
                     if (dcount != '0) state <= ST_SHIFT;
                  end else begin
                     dummy <= 1'b0;
                     cyc   <= quad_mode ? CYC_W'(BEATS_Q) : CYC_W'(BEATS_L);
                     state <= ST_SHIFT;
                  end
               end
            end
            ST_SHIFT: begin
               if (!enable) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  ph <= ~ph;
                  if (ph) begin
                     cyc <= cyc - 1'b1;
                     if (cyc == CYC_W'(1)) begin
                        state   <= ST_LOAD;
                        rx_push <= rx_en && !dummy;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   qxfer_bytecnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go),
      .load_val (byte_count),
      .dec      (dec),
      .count    (remaining)
   );

   qxfer_shifter #(.BYTE_W(BYTE_W), .LANES(LANES)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_val (tx_data),
      .shift    (shift_en),
      .quad     (quad_mode),
      .rx_en    (rx_en),
      .io_in    (io_in),
      .sh       (rx_data),
      .lane_out (lane_out)
   );

   assign data_phase = (state == ST_SHIFT) && !dummy;
   assign sclk       = (state == ST_SHIFT) && ph;
   assign cs_n       = (state == ST_IDLE);
   assign io_out     = data_phase ? lane_out : '0;
   assign io_oe      = !data_phase ? '0 :
                       quad_mode  ? (rx_en ? '0 : {LANES{1'b1}}) :
                                    {{(LANES-1){1'b0}}, 1'b1};

   // R2
   idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !enable) |=> (cs_n && $stable(remaining) && $stable(done)));
   // R5
   rem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |=> remaining == CNT_W'($past(remaining) - 1'b1));
   // R6
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && remaining == '0) |=> (cs_n && done));
   // R7
   push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push);
   // R8
   dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && dummy) |=> (!rx_push && $stable(remaining)));
   // R9
   stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && enable && remaining != '0 && !tx_valid) |=> (!sclk && !cs_n));
   // R10
   disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !cs_n) |=> (cs_n && done));
endmodule

// File: tb/qxfer_engine_test.sv
module qxfer_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, start = 1'b0, quad_mode = 1'b0, rx_en = 1'b0;
   logic [15:0] byte_count = '0;
   logic        tx_valid, tx_ctrl, tx_pop, rx_push, sclk, cs_n, done;
   logic [7:0]  tx_data, rx_data;
   logic [3:0]  io_out, io_oe;
   logic [3:0]  io_in = '0;
   logic [15:0] remaining;

   logic [7:0]  tq_data [0:31];
   logic        tq_ctrl [0:31];
   logic [4:0]  head = '0, tail = '0;
   logic        tq_hold = 1'b0;

   logic [3:0]  cap_lane [0:63];
   logic [3:0]  cap_oe   [0:63];
   logic [3:0]  src      [0:63];
   logic [7:0]  rx_cap   [0:7];
   int          rises = 0, src_i = 0, rx_n = 0;
   logic        sclk_prev = 1'b0;
   int          checks = 0, errors = 0;
   bit          fin = 1'b0;

   always #5 clk = ~clk;

   assign tx_valid = (head != tail) && !tq_hold;
   assign tx_data  = tq_data[head];
   assign tx_ctrl  = tq_ctrl[head];

   always @(posedge clk) if (tx_pop) head <= head + 5'd1;

   always @(negedge clk) begin
      if (sclk && !sclk_prev) begin
         if (rises < 64) begin
            cap_lane[rises] <= io_out;
            cap_oe[rises]   <= io_oe;
         end
         rises <= rises + 1;
         io_in <= src[src_i % 64];
         src_i <= src_i + 1;
      end
      sclk_prev <= sclk;
      if (rx_push) begin
         rx_cap[rx_n % 8] <= rx_data;
         rx_n <= rx_n + 1;
      end
   end

   qxfer_engine uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
      .quad_mode(quad_mode), .rx_en(rx_en), .byte_count(byte_count),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .cs_n(cs_n),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .done(done),
      .remaining(remaining)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push_entry(input logic [7:0] d, input logic c);
      tq_data[tail] = d;
      tq_ctrl[tail] = c;
      tail = tail + 5'd1;
   endtask

   task automatic clear_cap();
      rises = 0; src_i = 0; rx_n = 0;
      for (int i = 0; i < 64; i++) src[i] = 4'h0;
   endtask

   task automatic go(input int n, input logic q, input logic r);
      @(negedge clk);
      quad_mode = q; rx_en = r; byte_count = 16'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cs_n == 1'b0, "R1 cs_n after start", cs_n, 0);
      chk(done == 1'b0, "R1 done cleared", done, 0);
      chk(remaining == 16'(n), "R1 remaining loaded", remaining, n);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
      @(negedge clk);
      chk(done == 1'b1, "R6 done set", done, 1);
      chk(cs_n == 1'b1, "R6 cs_n released", cs_n, 1);
      chk(remaining == 16'd0, "R6 remaining zero", remaining, 0);
   endtask

   function automatic logic [7:0] leg_byte(input int base);
      logic [7:0] b;
      for (int k = 0; k < 8; k++) b[7-k] = cap_lane[base+k][0];
      return b;
   endfunction

   task automatic t_reset();
      chk(cs_n == 1'b1, "R6 reset cs_n", cs_n, 1);
      chk(sclk == 1'b0, "R9 reset sclk", sclk, 0);
      chk(done == 1'b0, "R6 reset done", done, 0);
      chk(remaining == 16'd0, "R5 reset remaining", remaining, 0);
      chk(io_oe == 4'h0, "R8 reset io_oe", io_oe, 0);
   endtask

   task automatic t_zero();
      @(negedge clk);
      byte_count = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R12 zero count done", done, 1);
      chk(cs_n == 1'b1, "R12 zero count cs_n", cs_n, 1);
   endtask

   task automatic t_legacy_tx();
      clear_cap();
      push_entry(8'hA5, 1'b0);
      push_entry(8'h3C, 1'b0);
      go(2, 1'b0, 1'b0);
      wait_done();
      chk(rises == 16, "R3 legacy clock count", rises, 16);
      chk(leg_byte(0) == 8'hA5, "R3 legacy byte0", leg_byte(0), 8'hA5);
      chk(leg_byte(8) == 8'h3C, "R3 legacy byte1", leg_byte(8), 8'h3C);
      chk(cap_oe[3] == 4'b0001, "R3 legacy io_oe", cap_oe[3], 1);
      chk(rx_n == 0, "R7 no push when tx only", rx_n, 0);
   endtask

   task automatic t_quad_tx();
      logic [7:0] b;
      clear_cap();
      push_entry(8'h12, 1'b0);
      push_entry(8'hEF, 1'b0);
      push_entry(8'h7B, 1'b0);
      go(3, 1'b1, 1'b0);
      wait_done();
      chk(rises == 6, "R4 quad clock count", rises, 6);
      b = {cap_lane[0], cap_lane[1]}; chk(b == 8'h12, "R4 quad byte0", b, 8'h12);
      b = {cap_lane[2], cap_lane[3]}; chk(b == 8'hEF, "R4 quad byte1", b, 8'hEF);
      b = {cap_lane[4], cap_lane[5]}; chk(b == 8'h7B, "R4 quad byte2", b, 8'h7B);
      chk(cap_oe[2] == 4'hF, "R4 quad io_oe", cap_oe[2], 4'hF);
   endtask

   task automatic t_legacy_rx();
      logic [7:0] pat;
      clear_cap();
      pat = 8'hC6;
      for (int k = 0; k < 8; k++) src[k] = {2'b00, pat[7-k], 1'b0};
      push_entry(8'h81, 1'b0);
      go(1, 1'b0, 1'b1);
      wait_done();
      chk(rx_n == 1, "R7 legacy push count", rx_n, 1);
      chk(rx_cap[0] == 8'hC6, "R7 legacy rx byte", rx_cap[0], 8'hC6);
      chk(leg_byte(0) == 8'h81, "R3 full duplex tx byte", leg_byte(0), 8'h81);
   endtask

   task automatic t_quad_rx();
      clear_cap();
      src[0] = 4'h9; src[1] = 4'hE; src[2] = 4'h4; src[3] = 4'h7;
      push_entry(8'h00, 1'b0);
      push_entry(8'h00, 1'b0);
      go(2, 1'b1, 1'b1);
      wait_done();
      chk(rx_n == 2, "R7 quad push count", rx_n, 2);
      chk(rx_cap[0] == 8'h9E, "R7 quad rx byte0", rx_cap[0], 8'h9E);
      chk(rx_cap[1] == 8'h47, "R7 quad rx byte1", rx_cap[1], 8'h47);
      chk(cap_oe[1] == 4'h0, "R11 quad rx io_oe", cap_oe[1], 0);
   endtask

   task automatic t_dummy();
      clear_cap();
      push_entry(8'hF0, 1'b0);
      push_entry(8'h03, 1'b1);
      push_entry(8'h0F, 1'b0);
      go(2, 1'b0, 1'b1);
      wait_done();
      chk(rises == 19, "R8 dummy clock count", rises, 19);
      chk(leg_byte(0) == 8'hF0, "R8 byte before dummy", leg_byte(0), 8'hF0);
      chk(leg_byte(11) == 8'h0F, "R8 byte after dummy", leg_byte(11), 8'h0F);
      for (int k = 8; k < 11; k++)
         chk(cap_oe[k] == 4'h0, "R8 dummy lines released", cap_oe[k], 0);
      chk(rx_n == 2, "R8 dummy gives no push", rx_n, 2);
   endtask

   task automatic t_stall();
      clear_cap();
      tq_hold = 1'b1;
      push_entry(8'h5A, 1'b0);
      go(1, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      chk(rises == 0, "R9 no clock while starved", rises, 0);
      chk(cs_n == 1'b0, "R9 cs_n held while starved", cs_n, 0);
      chk(remaining == 16'd1, "R9 remaining held", remaining, 1);
      tq_hold = 1'b0;
      wait_done();
      chk(leg_byte(0) == 8'h5A, "R9 byte after stall", leg_byte(0), 8'h5A);
   endtask

   task automatic t_disable();
      clear_cap();
      for (int i = 0; i < 4; i++) push_entry(8'h11, 1'b0);
      go(4, 1'b0, 1'b0);
      repeat (7) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(cs_n == 1'b1, "R10 cs_n after disable", cs_n, 1);
      chk(done == 1'b1, "R10 done after disable", done, 1);
      chk(sclk == 1'b0, "R10 sclk after disable", sclk, 0);
      tail = head;
   endtask

   task automatic t_ignore();
      logic [15:0] r0;
      r0 = remaining;
      @(negedge clk);
      byte_count = 16'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(cs_n == 1'b1, "R2 cs_n stays high", cs_n, 1);
      chk(remaining == r0, "R2 remaining unchanged", remaining, r0);
      chk(done == 1'b1, "R2 done unchanged", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      enable = 1'b1;
      t_zero();
      t_legacy_tx();
      t_quad_tx();
      t_legacy_rx();
      t_quad_rx();
      t_dummy();
      t_stall();
      t_disable();
      t_ignore();
      if (!fin) begin
         fin = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule